// File: doc/BRIEF.md
# Execution Trace PC Reconstructor

This block takes a stream of 36-bit execution trace words from a small core and works out which instruction each word belongs to. The core reports only branch targets, memory addresses of loads and stores, and results. It does not report the program counter of ordinary instructions. The block therefore keeps its own copy of the program counter. It looks up the instruction stored at that address through a synchronous instruction-memory read port, and it steps forward by the length of that instruction.

For every accepted trace word the block produces one record. A record holds the word's flag nibble, the payload, the reconstructed PC, the fetched instruction word and a status code. When the block has no valid PC, or has just lost track because memory holds nothing at the tracked address, it marks records as skipping. It stays in that state until a branch word supplies a new starting point.

Interrupt entry is handled by forcing the tracked PC to a fixed vector whenever the interrupt-active flag rises between consecutive words. Input and output are both valid/ready streams, and the block handles one word at a time.

Top module: `trace_recon`

## Requirements
- R1: The trace word is split into fields as follows. Bits 31:0 are the payload. Bit 32 marks a branch entry, bit 33 marks a memory-address entry and bit 35 is the interrupt-active flag. Each record carries the word's bits 35:32 unchanged on `rec_flags_o` and bits 31:0 on `rec_payload_o`. Any bit of the word that is not a clean 1 is taken as 0.
- R2: After reset the PC is unknown. Until a branch word arrives, every record has status 2 (skipping), with `rec_pc_o` and `rec_insn_o` equal to 0.
- R3: After any record of a branch word is produced, whatever its status, the tracked PC equals that word's payload and is known.
- R4: A memory-address word that is not a branch leaves the tracked PC unchanged.
- R5: With a known PC and a memory hit, the record has status 0 (ok), the tracked PC as `rec_pc_o` and the fetched word as `rec_insn_o`. For a word that is not an address entry, the PC then advances by 4 when the instruction's bits 1:0 are 2'b11, and by 2 otherwise.
- R6: When a word has the interrupt flag set and the previous accepted word had it clear, the tracked PC becomes `IRQ_VECTOR` (0x10) and known before the word is processed.
- R7: With a known PC and no memory hit, the record has status 1 (no information), `rec_pc_o` equals the tracked PC and `rec_insn_o` is 0. The PC then becomes unknown unless the word is a branch.
- R8: In the cycle a word is accepted with a known PC, `imem_req_o` is 1 and `imem_addr_o` holds that PC. `imem_hit_i` and `imem_rdata_i` are sampled one cycle later. No request is made while the PC is unknown.
- R9: `trc_ready_o` is 1 only while no word is in flight. The record becomes valid 2 cycles after the accepting edge, and `trc_ready_o` returns in the cycle after the record is taken.
- R10: While `rec_valid_o` is 1 and `rec_ready_i` is 0, every record output stays stable.
- R11: The previous interrupt flag is updated by every accepted word, skipping ones included. A second consecutive word with the flag set does not force the vector again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trc_valid_i | input | 1 | Trace word valid |
| trc_data_i | input | 36 | Trace word |
| trc_ready_o | output | 1 | Block can accept a trace word |
| imem_req_o | output | 1 | Instruction lookup request |
| imem_addr_o | output | 32 | Lookup address |
| imem_hit_i | input | 1 | Memory holds an instruction at the address (one cycle after request) |
| imem_rdata_i | input | 32 | Instruction word (one cycle after request) |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Downstream accepts record |
| rec_flags_o | output | 4 | Bits 35:32 of the trace word |
| rec_payload_o | output | 32 | Bits 31:0 of the trace word |
| rec_pc_o | output | 32 | Reconstructed PC (0 when skipping) |
| rec_insn_o | output | 32 | Fetched instruction (0 unless status ok) |
| rec_status_o | output | 2 | 0 ok, 1 no information, 2 skipping |

## Verification
The lookup request and its address are due in the same cycle as the accepting edge. The bench checks them just after driving the word at the falling edge, before that edge arrives. The memory model answers one edge later, and the record is due at the second falling edge after acceptance. The bench checks `trc_ready_o` and `rec_valid_o` at every falling edge in between and compares all record fields there. During hold periods the bench re-checks the record on each falling edge. After the release edge it checks that `rec_valid_o` has dropped and that `trc_ready_o` is back.

// File: rtl/trace_recon_pkg.sv
package trace_recon_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned TRC_W  = XLEN + FLAG_W;
  // positions inside the flag nibble
  localparam int unsigned F_BRANCH = 0;
  localparam int unsigned F_ADDR   = 1;
  localparam int unsigned F_IRQ    = 3;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NOINFO = 2'd1,
    ST_SKIP   = 2'd2
  } rec_status_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RSP  = 2'd1,
    PH_OUT  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [XLEN-1:0]   payload;
  } trc_word_t;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [XLEN-1:0]   payload;
    logic [XLEN-1:0]   pc;
    logic [XLEN-1:0]   insn;
    rec_status_e       status;
  } rec_t;

  function automatic logic [XLEN-1:0] insn_step(input logic [1:0] lo);
    return (lo == 2'b11) ? XLEN'(4) : XLEN'(2);
  endfunction
endpackage

// File: rtl/trc_field_dec.sv
module trc_field_dec
  import trace_recon_pkg::*;
(
  input  logic [TRC_W-1:0] raw_i,
  output trc_word_t        word_o
);
  logic [TRC_W-1:0] clean;

  // undefined digits collapse to zero
  for (genvar b = 0; b < TRC_W; b++) begin : g_bit
    assign clean[b] = (raw_i[b] === 1'b1);
  end

  assign word_o.payload = clean[XLEN-1:0];
  assign word_o.flags   = clean[TRC_W-1:XLEN];
endmodule

// File: rtl/trc_pc_track.sv
module trc_pc_track
  import trace_recon_pkg::*;
#(
  parameter logic [XLEN-1:0] IRQ_VECTOR = 32'h10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            in_irq_i,
  input  logic            commit_i,
  input  logic            branch_i,
  input  logic            addr_i,
  input  logic [XLEN-1:0] payload_i,
  input  logic            hit_i,
  input  logic [1:0]      insn_lo_i,
  output logic [XLEN-1:0] look_pc_o,
  output logic            look_known_o,
  output logic [XLEN-1:0] cur_pc_o,
  output logic            cur_known_o
);
  logic [XLEN-1:0] pc_q;
  logic            known_q;
  logic            prev_irq_q;
  logic            irq_rise;

  assign irq_rise     = in_irq_i & ~prev_irq_q;
  assign look_pc_o    = irq_rise ? IRQ_VECTOR : pc_q;
  assign look_known_o = irq_rise | known_q;
  assign cur_pc_o     = pc_q;
  assign cur_known_o  = known_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      known_q    <= 1'b0;
      prev_irq_q <= 1'b0;
    end else if (accept_i) begin
      prev_irq_q <= in_irq_i;
      if (irq_rise) begin
        pc_q    <= IRQ_VECTOR;
        known_q <= 1'b1;
      end
    end else if (commit_i) begin
      if (branch_i) begin
        pc_q    <= payload_i;
        known_q <= 1'b1;
      end else if (known_q && !hit_i) begin
        known_q <= 1'b0;
      end else if (known_q && !addr_i) begin
        pc_q <= pc_q + insn_step(insn_lo_i);
      end
    end
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && addr_i && !branch_i |=> $stable(pc_q));
  // R6
  irq_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && in_irq_i && !prev_irq_q |=> known_q && pc_q == IRQ_VECTOR);
  // R7
  miss_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && known_q && !hit_i && !branch_i |=> !known_q);
  // R3
  branch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && branch_i |=> known_q && pc_q == $past(payload_i));
endmodule

// File: rtl/trc_rec_hold.sv
module trc_rec_hold
  import trace_recon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  rec_t rec_i,
  input  logic take_i,
  output logic valid_o,
  output rec_t rec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rec_o   <= '{status: ST_SKIP, default: '0};
    end else if (load_i) begin
      valid_o <= 1'b1;
      rec_o   <= rec_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !take_i |=> valid_o && $stable(rec_o));
endmodule

// File: rtl/trace_recon.sv
module trace_recon
  import trace_recon_pkg::*;
#(
  parameter logic [XLEN-1:0] IRQ_VECTOR = 32'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trc_valid_i,
  input  logic [TRC_W-1:0]  trc_data_i,
  output logic              trc_ready_o,
  output logic              imem_req_o,
  output logic [XLEN-1:0]   imem_addr_o,
  input  logic              imem_hit_i,
  input  logic [XLEN-1:0]   imem_rdata_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [FLAG_W-1:0] rec_flags_o,
  output logic [XLEN-1:0]   rec_payload_o,
  output logic [XLEN-1:0]   rec_pc_o,
  output logic [XLEN-1:0]   rec_insn_o,
  output logic [1:0]        rec_status_o
);
  phase_e    phase_q, phase_d;
  trc_word_t in_word, wd_q;
  rec_t      rec_new, rec_out;
  logic      accept, commit, take;
  logic [XLEN-1:0] look_pc, cur_pc;
  logic      look_known, cur_known;

  trc_field_dec u_dec (.raw_i(trc_data_i), .word_o(in_word));

  assign trc_ready_o = (phase_q == PH_IDLE);
  assign accept      = trc_valid_i & trc_ready_o;
  assign commit      = (phase_q == PH_RSP);
  assign take        = rec_valid_o & rec_ready_i;

  assign imem_req_o  = accept & look_known;
  assign imem_addr_o = look_pc;

  trc_pc_track #(.IRQ_VECTOR(IRQ_VECTOR)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .in_irq_i    (in_word.flags[F_IRQ]),
    .commit_i    (commit),
    .branch_i    (wd_q.flags[F_BRANCH]),
    .addr_i      (wd_q.flags[F_ADDR]),
    .payload_i   (wd_q.payload),
    .hit_i       (imem_hit_i),
    .insn_lo_i   (imem_rdata_i[1:0]),
    .look_pc_o   (look_pc),
    .look_known_o(look_known),
    .cur_pc_o    (cur_pc),
    .cur_known_o (cur_known)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wd_q <= '0;
    else if (accept) wd_q <= in_word;
  end

  always_comb begin
    rec_new.flags   = wd_q.flags;
    rec_new.payload = wd_q.payload;
    rec_new.pc      = '0;
    rec_new.insn    = '0;
    rec_new.status  = ST_SKIP;
    if (cur_known) begin
      rec_new.pc = cur_pc;
      if (imem_hit_i) begin
        rec_new.insn   = imem_rdata_i;
        rec_new.status = ST_OK;
      end else begin
        rec_new.status = ST_NOINFO;
      end
    end
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_RSP;
      PH_RSP:  phase_d = PH_OUT;
      PH_OUT:  if (take) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else phase_q <= phase_d;
  end

  trc_rec_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit),
    .rec_i  (rec_new),
    .take_i (rec_ready_i),
    .valid_o(rec_valid_o),
    .rec_o  (rec_out)
  );

  assign rec_flags_o   = rec_out.flags;
  assign rec_payload_o = rec_out.payload;
  assign rec_pc_o      = rec_out.pc;
  assign rec_insn_o    = rec_out.insn;
  assign rec_status_o  = rec_out.status;

  // R9
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !trc_ready_o);
  // R9
  rec_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> ##2 rec_valid_o);
  // R8
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |-> trc_valid_i && trc_ready_o);
  // R2
  skip_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_status_o == 2'd2 |-> rec_pc_o == '0 && rec_insn_o == '0);
endmodule

// File: tb/sim_trace_recon.sv
module sim_trace_recon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trc_valid = 1'b0;
  logic [35:0] trc_data = '0;
  logic        trc_ready;
  logic        imem_req;
  logic [31:0] imem_addr;
  logic        imem_hit = 1'b0;
  logic [31:0] imem_rdata = '0;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic [3:0]  rec_flags;
  logic [31:0] rec_payload, rec_pc, rec_insn;
  logic [1:0]  rec_status;

  int total = 0;
  int bad = 0;

  // reference state
  bit      m_known = 0;
  bit      m_prev_irq = 0;
  int unsigned m_pc = 0;

  always #5 clk = ~clk;

  trace_recon u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .trc_valid_i(trc_valid), .trc_data_i(trc_data), .trc_ready_o(trc_ready),
    .imem_req_o(imem_req), .imem_addr_o(imem_addr),
    .imem_hit_i(imem_hit), .imem_rdata_i(imem_rdata),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready),
    .rec_flags_o(rec_flags), .rec_payload_o(rec_payload),
    .rec_pc_o(rec_pc), .rec_insn_o(rec_insn), .rec_status_o(rec_status)
  );

  function automatic bit mem_has(input int unsigned a);
    return a < 32'h200;
  endfunction

  function automatic logic [31:0] mem_word(input int unsigned a);
    logic [31:0] v;
    v = {a[15:0], 8'hA5, 8'h00};
    v[1:0] = (a[3:2] == 2'b11) ? 2'b10 : 2'b11;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    imem_hit   <= imem_req && mem_has(imem_addr);
    imem_rdata <= (imem_req && mem_has(imem_addr)) ? mem_word(imem_addr) : 32'h0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] mk(input bit irq, input bit ad, input bit br, input logic [31:0] p);
    return {irq, 1'b0, ad, br, p};
  endfunction

  task automatic send(input logic [35:0] w, input int hold, input string tag);
    bit irq, ad, br, exp_req;
    int unsigned exp_pc, exp_insn, exp_st, exp_addr;
    irq = w[35]; ad = w[33]; br = w[32];
    if (irq && !m_prev_irq) begin m_pc = 32'h10; m_known = 1; end
    m_prev_irq = irq;
    exp_req = m_known;
    exp_addr = m_pc;
    if (!m_known) begin
      exp_st = 2; exp_pc = 0; exp_insn = 0;
    end else if (mem_has(m_pc)) begin
      exp_st = 0; exp_pc = m_pc; exp_insn = mem_word(m_pc);
      if (!ad) m_pc = m_pc + ((exp_insn[1:0] == 2'b11) ? 4 : 2);
    end else begin
      exp_st = 1; exp_pc = m_pc; exp_insn = 0;
      m_known = 0;
    end
    if (br) begin m_pc = w[31:0]; m_known = 1; end

    @(negedge clk);
    chk(trc_ready == 1'b1, "R9 ready idle", trc_ready, 1);
    trc_valid = 1'b1; trc_data = w;
    #1;
    chk(imem_req == exp_req, "R8 req", imem_req, exp_req);
    if (exp_req) chk(imem_addr == exp_addr, {"R8 addr ", tag}, imem_addr, exp_addr);
    @(negedge clk);
    trc_valid = 1'b0;
    chk(trc_ready == 1'b0 && rec_valid == 1'b0, "R9 busy", {trc_ready, rec_valid}, 0);
    @(negedge clk);
    for (int h = 0; h <= hold; h++) begin
      chk(rec_valid == 1'b1, "R9 rec valid", rec_valid, 1);
      chk(trc_ready == 1'b0, "R9 ready low", trc_ready, 0);
      chk(rec_status == exp_st[1:0], {"status ", tag}, rec_status, exp_st);
      chk(rec_pc == exp_pc, {"pc ", tag}, rec_pc, exp_pc);
      chk(rec_insn == exp_insn, {"insn ", tag}, rec_insn, exp_insn);
      chk(rec_flags == w[35:32] && rec_payload == w[31:0], "R1 fields",
          {rec_flags, rec_payload}, w);
      if (h != hold) begin
        if (h > 0) chk(1'b1, "R10 hold", 0, 0);
        @(negedge clk);
      end
    end
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
    chk(rec_valid == 1'b0, "R9 taken", rec_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trc_ready == 1'b1, "R9 reset ready", trc_ready, 1);
    chk(rec_valid == 1'b0, "R9 reset valid", rec_valid, 0);
    chk(imem_req == 1'b0, "R8 reset req", imem_req, 0);

    send(mk(0, 0, 0, 32'h1234), 0, "R2 plain unknown");
    send(mk(0, 1, 0, 32'h8000), 2, "R2 addr unknown R10");
    send(mk(0, 0, 1, 32'h40), 0, "R3 first branch");
    send(mk(0, 0, 0, 32'h5), 1, "R5 ok at 40");
    send(mk(0, 1, 0, 32'h9000), 0, "R4 addr at 44");
    for (int i = 0; i < 5; i++) send(mk(0, 0, 0, i), 0, "R5 step");
    send(mk(0, 0, 1, 32'h1FC), 0, "R3 branch ok");
    send(mk(0, 0, 0, 32'h1), 0, "R5 compressed 1FC");
    send(mk(0, 0, 0, 32'h2), 0, "R5 compressed 1FE");
    send(mk(0, 0, 0, 32'h3), 0, "R7 miss at 200");
    send(mk(0, 0, 0, 32'h4), 0, "R7 skip after miss");
    send(mk(1, 0, 0, 32'hA), 0, "R6 irq entry");
    send(mk(1, 0, 0, 32'hB), 0, "R11 irq no reforce");
    send(mk(0, 0, 0, 32'hC), 0, "R5 irq off");
    send(mk(1, 1, 0, 32'hD), 0, "R6 irq reentry addr");
    send(mk(1, 0, 1, 32'h400), 0, "R3 branch out");
    send(mk(1, 0, 0, 32'hE), 0, "R7 miss at 400");
    send(mk(1, 0, 0, 32'hF), 0, "R11 skip irq held");
    send(mk(0, 0, 1, 32'h20), 0, "R3 resync");
    send(mk(0, 0, 0, 32'h10), 3, "R10 ok at 20 held");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule